// File: doc/BRIEF.md
# Rotating Single-Light Pattern Controller

This block drives a row of lamps so that exactly one lamp is lit at any time. A 2-bit mode input is sampled on every rising clock edge. Depending on that mode, the lit lamp jumps back to the leftmost position, moves one place to the right, moves one place to the left, or stays where it is. At both ends of the row the movement wraps around to the opposite end.

Inside, the block stores the lit position as a small binary index. A separate combinational decoder turns that index into the one-hot lamp vector, so the lamp outputs change only after a clock edge. The block has no dedicated reset pin. The clear mode acts as a synchronous reset, and until the first edge taken in that mode the lamp outputs are undefined. The lamp count is a parameter and defaults to four.

Top module: `light_rotator`

## Requirements
- R1: On a rising edge with `sel` = 2'b00 (clear), the position returns to its start, and afterwards `lamps` equals 4'b1000 (only bit 3 lit), whatever state it held before.
- R2: On a rising edge with `sel` = 2'b01 (step right), the lit bit moves from bit i to bit i-1 when i is above 0.
- R3: Stepping right with bit 0 lit wraps the lit bit to bit 3 (4'b0001 becomes 4'b1000).
- R4: On a rising edge with `sel` = 2'b10 (step left), the lit bit moves from bit i to bit i+1 when i is below 3.
- R5: Stepping left with bit 3 lit wraps the lit bit to bit 0 (4'b1000 becomes 4'b0001).
- R6: On a rising edge with `sel` = 2'b11 (freeze), `lamps` keeps its value.
- R7: After the first clear edge, exactly one bit of `lamps` is high in every cycle.
- R8: A change of `sel` between clock edges has no effect on `lamps` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All position updates happen on its rising edge. |
| sel | input | 2 | Mode code: 00 clear, 01 step right, 10 step left, 11 freeze. |
| lamps | output | LIGHTS (4) | One-hot lamp vector. Bit 3 is the leftmost lamp. |

## Verification
The hardest cases to reach from the ports are the two wrap-arounds. The right wrap needs three right steps after a clear before it appears, and the left wrap needs a left step taken directly from the clear position. The stimulus therefore runs long right and left runs that cross each end more than once. It also switches direction in consecutive cycles and issues a clear from the middle of the row. Between edges it changes the mode to show that the lamps wait for the next edge before they move.

// File: rtl/lr_pkg.sv
package lr_pkg;

   typedef enum logic [1:0] {
      LR_CLEAR      = 2'b00,
      LR_STEP_RIGHT = 2'b01,
      LR_STEP_LEFT  = 2'b10,
      LR_FREEZE     = 2'b11
   } lr_mode_e;

   typedef struct packed {
      logic clear;
      logic advance;
      logic retreat;
   } lr_ctrl_t;

endpackage

// File: rtl/lr_mode_decode.sv
module lr_mode_decode
   import lr_pkg::*;
(
   input  logic [1:0] sel,
   output lr_ctrl_t   ctrl
);

   lr_mode_e mode;

   always_comb begin
      mode = lr_mode_e'(sel);
      ctrl = '0;
      case (mode)
         LR_CLEAR:      ctrl.clear   = 1'b1;
         LR_STEP_RIGHT: ctrl.advance = 1'b1;
         LR_STEP_LEFT:  ctrl.retreat = 1'b1;
         default:       ctrl = '0;
      endcase
   end

endmodule

// File: rtl/lr_position_reg.sv
module lr_position_reg
   import lr_pkg::*;
#(
   parameter int LIGHTS = 4,
   parameter int POS_W  = (LIGHTS > 1) ? $clog2(LIGHTS) : 1
) (
   input  logic             clk,
   input  lr_ctrl_t         ctrl,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(LIGHTS - 1);
   localparam bit               IS_POW2  = ((LIGHTS & (LIGHTS - 1)) == 0);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_up;
   logic [POS_W-1:0] pos_down;
   logic [POS_W-1:0] pos_d;

   generate
      if (IS_POW2) begin : g_natural_wrap
         always_comb begin
            pos_up   = pos_q + POS_W'(1);
            pos_down = pos_q - POS_W'(1);
         end
      end else begin : g_compare_wrap
         always_comb begin
            pos_up   = (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
            pos_down = (pos_q == '0) ? LAST_POS : pos_q - POS_W'(1);
         end
      end
   endgenerate

   always_comb begin
      pos_d = pos_q;
      if (ctrl.clear)
         pos_d = '0;
      else if (ctrl.advance)
         pos_d = pos_up;
      else if (ctrl.retreat)
         pos_d = pos_down;
   end

   always_ff @(posedge clk) begin
      pos_q <= pos_d;
   end

   assign pos = pos_q;

endmodule

// File: rtl/lr_onehot_decode.sv
module lr_onehot_decode #(
   parameter int LIGHTS = 4,
   parameter int POS_W  = (LIGHTS > 1) ? $clog2(LIGHTS) : 1
) (
   input  logic [POS_W-1:0]  pos,
   output logic [LIGHTS-1:0] lamps
);

   generate
      for (genvar i = 0; i < LIGHTS; i++) begin : g_lamp
         localparam logic [POS_W-1:0] MATCH = POS_W'(LIGHTS - 1 - i);
         assign lamps[i] = (pos == MATCH);
      end
   endgenerate

endmodule

// File: rtl/light_rotator.sv
module light_rotator
   import lr_pkg::*;
#(
   parameter int LIGHTS = 4
) (
   input  logic              clk,
   input  logic [1:0]        sel,
   output logic [LIGHTS-1:0] lamps
);

   localparam int POS_W = (LIGHTS > 1) ? $clog2(LIGHTS) : 1;

   generate
      if (LIGHTS < 2) begin : g_bad_lights
         $error("light_rotator: LIGHTS must be at least 2");
      end
      if (LIGHTS > 1024) begin : g_big_lights
         $error("light_rotator: LIGHTS above 1024 is not supported");
      end
   endgenerate

   lr_ctrl_t         ctrl;
   logic [POS_W-1:0] pos;

   lr_mode_decode u_mode (
      .sel  (sel),
      .ctrl (ctrl)
   );

   lr_position_reg #(
      .LIGHTS (LIGHTS),
      .POS_W  (POS_W)
   ) u_pos (
      .clk  (clk),
      .ctrl (ctrl),
      .pos  (pos)
   );

   lr_onehot_decode #(
      .LIGHTS (LIGHTS),
      .POS_W  (POS_W)
   ) u_dec (
      .pos   (pos),
      .lamps (lamps)
   );

endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
   parameter int LIGHTS = 4
) (
   input logic              clk,
   input logic [1:0]        sel,
   input logic [LIGHTS-1:0] lamps
);

   localparam logic [LIGHTS-1:0] START = {1'b1, {(LIGHTS-1){1'b0}}};

   logic primed = 1'b0;

   always @(posedge clk) begin
      if (sel == 2'b00)
         primed <= 1'b1;
   end

   AST_CLEAR_TO_START: assert property (@(posedge clk) disable iff (!primed)
      (sel == 2'b00) |=> (lamps == START)); // R1

   AST_STEP_RIGHT: assert property (@(posedge clk) disable iff (!primed)
      (sel == 2'b01) |=> (lamps == {$past(lamps[0]), $past(lamps[LIGHTS-1:1])})); // R2

   AST_STEP_LEFT: assert property (@(posedge clk) disable iff (!primed)
      (sel == 2'b10) |=> (lamps == {$past(lamps[LIGHTS-2:0]), $past(lamps[LIGHTS-1])})); // R4

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!primed)
      (sel == 2'b11) |=> $stable(lamps)); // R6

   AST_ONE_LIT: assert property (@(posedge clk) disable iff (!primed)
      $countones(lamps) == 1); // R7

endmodule

bind light_rotator lr_checker #(.LIGHTS(LIGHTS)) u_chk (
   .clk   (clk),
   .sel   (sel),
   .lamps (lamps)
);

// File: tb/sim_light_rotator.sv
`timescale 1ns/1ps
module sim_light_rotator;

   logic       clk = 1'b0;
   logic [1:0] sel = 2'b00;
   logic [3:0] lamps;

   int errors = 0;
   int checks = 0;
   int pos    = 0;   // reference position: 0 means leftmost lamp lit

   always #5 clk = ~clk;

   light_rotator #(.LIGHTS(4)) u0 (
      .clk   (clk),
      .sel   (sel),
      .lamps (lamps)
   );

   function automatic logic [3:0] expect_q(int p);
      return 4'b1000 >> p;
   endfunction

   task automatic check(string req, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: lamps=%b expected=%b", req, got, exp);
      end
   endtask

   // drive one mode for one edge, advance the model, check at the next falling edge
   task automatic step(logic [1:0] m);
      int    prev;
      string tag;
      sel = m;
      @(posedge clk);
      prev = pos;
      case (m)
         2'b00: pos = 0;
         2'b01: pos = (pos + 1) % 4;
         2'b10: pos = (pos + 3) % 4;
         default: pos = pos;
      endcase
      @(negedge clk);
      case (m)
         2'b00: tag = "R1";
         2'b01: tag = (prev == 3) ? "R3" : "R2";
         2'b10: tag = (prev == 0) ? "R5" : "R4";
         default: tag = "R6";
      endcase
      check(tag, lamps, expect_q(pos));
      checks++;
      if ($countones(lamps) != 1) begin
         errors++;
         $display("FAIL R7: lamps=%b expected exactly one bit set", lamps);
      end
   endtask

   // change the mode between edges and confirm the lamps do not move
   task automatic mid_cycle(logic [1:0] m);
      sel = m;
      #2;
      check("R8", lamps, expect_q(pos));
   endtask

   initial begin
      @(negedge clk);
      step(2'b00);                              // R1 first clear
      step(2'b00);                              // R1 clear while at start
      for (int i = 0; i < 6; i++) step(2'b01);  // R2, wraps once: R3
      for (int i = 0; i < 3; i++) step(2'b11);  // R6
      for (int i = 0; i < 6; i++) step(2'b10);  // R4, wraps: R5
      step(2'b00);                              // R1 from middle
      step(2'b10);                              // R5 direct left wrap from start
      step(2'b01);                              // R3 right wrap back
      step(2'b01);                              // R2
      step(2'b10);                              // R4 direction flip
      step(2'b01);                              // R2
      mid_cycle(2'b00);                         // R8
      step(2'b11);                              // R6
      mid_cycle(2'b10);                         // R8
      step(2'b01);                              // R2
      step(2'b00);                              // R1 clear from position 2
      for (int i = 0; i < 9; i++) step(2'b01);  // R2 / R3 repeated crossings
      for (int i = 0; i < 9; i++) step(2'b10);  // R4 / R5 repeated crossings
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule